// File: doc/BRIEF.md
# Carry-Gated Compare and Bitwise Logic Execute Unit

This block is the execute step for the compare and bitwise-logic group of a small core with 24-bit registers. Each cycle it may accept one decoded operation: a group select (logic or compare), a 4-bit register-form subcode, an immediate-form flag, the rd and rs register values, a 7-bit immediate and the current C, V, Z and N flags. One clock edge later it presents a register write-back value with its write enable and the next-state values of the four flags.

Register forms are predicated on the carry flag through the upper two subcode bits. An operation whose predicate fails becomes a no-op: nothing is written and the flags come back unchanged. Logic operations act on the low 16 bits and clear the upper byte of rd. The compare group offers a full-width plain compare and a 16-bit compare that also subtracts the carry. Compares only set flags and never write rd. Immediate forms always execute, and they pick their function from the low two subcode bits.

Top module: `cond_cmp_logic_unit`

## Requirements
- R1: The outputs for an operation presented with `in_valid` high are registered at the next rising clock edge, and `done` is high in exactly that cycle.
- R2: For the logic group (`in_grp`=0), `in_sub[1:0]` selects the function of rd[15:0] and the source: 00 AND, 01 OR, 10 XOR, 11 NOT of the source alone.
- R3: For register forms, `in_sub[3:2]` sets the predicate: 10 always executes, 00 executes only with C=1, 01 only with C=0, and 11 never executes. An operation that does not execute drives `wb_en`=0, `wb_data`=0 and returns all four flags equal to their inputs. Immediate forms (`in_imm`=1) always execute.
- R4: An executed logic operation asserts `wb_en` and drives `wb_data[23:16]`=0, with the 16-bit result in `wb_data[15:0]`.
- R5: In immediate logic forms, the source is the 7-bit immediate sign-extended to 16 bits. Immediate NOT writes the inverse of that extended value.
- R6: After an executed logic operation, V=0, Z=1 exactly when the 16-bit result is zero, N equals result bit 15, and C equals `c_in`.
- R7: The plain compare (`in_grp`=1, `in_sub[1:0]`=00) forms the 24-bit rd minus rs, or rd minus the zero-extended immediate. C is the unsigned borrow, V the signed overflow, Z is set on a zero difference and N is bit 23.
- R8: The carry compare (`in_grp`=1, `in_sub[1:0]`=01) forms rd[15:0] minus the 16-bit source minus C, where the immediate is sign-extended to 16 bits. C, V, Z and N come from this 16-bit difference: borrow, signed overflow, zero, and bit 15.
- R9: A compare never asserts `wb_en` and drives `wb_data`=0.
- R10: In the compare group, `in_sub[1:0]` values 10 and 11 are no-ops: no write, and the flags equal their inputs.
- R11: In a cycle after `in_valid` was low, `done` and `wb_en` are 0 and the flag outputs equal the flag inputs of the previous cycle.
- R12: While reset is active, and until the internal reset is released, `done`, `wb_en`, `wb_data` and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An operation is presented this cycle |
| in_grp | input | 1 | 0 = logic group, 1 = compare group |
| in_imm | input | 1 | 1 = immediate form, always executes |
| in_sub | input | 4 | Subcode: [3:2] predicate, [1:0] function |
| in_rd | input | 24 | Destination register value |
| in_rs | input | 24 | Source register value |
| in_imm7 | input | 7 | Immediate operand |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| z_in | input | 1 | Current zero flag |
| n_in | input | 1 | Current negative flag |
| done | output | 1 | Result of an accepted operation is present |
| wb_en | output | 1 | Write wb_data to rd |
| wb_data | output | 24 | Write-back value |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |
| z_out | output | 1 | Next zero flag |
| n_out | output | 1 | Next negative flag |

## Verification
The properties assume that every input is a known value in any cycle the clock samples it. They also assume that the inputs of one cycle relate to the outputs of the next only through a single register stage, and that no check needs to look past the internal reset release. The bench drives all inputs at the falling edge, keeps them at defined values from time zero, and holds `in_valid` low until several cycles after reset release. It drives the flag inputs with explicit patterns, so that the hold, clear and pass-through rules are each observed against a known prior value.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [1:0] {
    LF_AND = 2'b00,
    LF_OR  = 2'b01,
    LF_XOR = 2'b10,
    LF_NOT = 2'b11
  } logic_fn_e;

  typedef enum logic [1:0] {
    CF_FULL   = 2'b00,
    CF_BORROW = 2'b01,
    CF_RSV2   = 2'b10,
    CF_RSV3   = 2'b11
  } cmp_fn_e;

  typedef enum logic [1:0] {
    PR_IF_C   = 2'b00,
    PR_IF_NC  = 2'b01,
    PR_ALWAYS = 2'b10,
    PR_NEVER  = 2'b11
  } pred_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } flags_t;

endpackage

// File: rtl/ccu_rst_sync.sv
module ccu_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_s = stage2_q;

endmodule

// File: rtl/ccu_gate.sv
module ccu_gate
  import ccu_pkg::*;
(
  input  logic       imm_form,
  input  logic [1:0] pred,
  input  logic       c_flag,
  output logic       exec
);

  always_comb begin
    if (imm_form) begin
      exec = 1'b1;
    end else begin
      case (pred_e'(pred))
        PR_ALWAYS: exec = 1'b1;
        PR_IF_C:   exec = c_flag;
        PR_IF_NC:  exec = ~c_flag;
        default:   exec = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ccu_logic.sv
module ccu_logic
  import ccu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         neg
);

  always_comb begin
    case (logic_fn_e'(fn))
      LF_AND:  res = a & b;
      LF_OR:   res = a | b;
      LF_XOR:  res = a ^ b;
      default: res = ~b;
    endcase
  end

  assign zero = (res == '0);
  assign neg  = res[W-1];

endmodule

// File: rtl/ccu_sub.sv
module ccu_sub #(
  parameter int W = 24
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         bin,
  output logic         borrow,
  output logic         ovf,
  output logic         zero,
  output logic         neg
);

  logic [W:0]   wide;
  logic [W-1:0] diff;

  assign wide   = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};
  assign diff   = wide[W-1:0];
  assign borrow = wide[W];
  assign ovf    = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
  assign zero   = (diff == '0);
  assign neg    = diff[W-1];

endmodule

// File: rtl/cond_cmp_logic_unit.sv
module cond_cmp_logic_unit
  import ccu_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int LOGIC_W = 16,
  parameter int IMM_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_grp,
  input  logic              in_imm,
  input  logic [3:0]        in_sub,
  input  logic [DATA_W-1:0] in_rd,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [IMM_W-1:0]  in_imm7,
  input  logic              c_in,
  input  logic              v_in,
  input  logic              z_in,
  input  logic              n_in,
  output logic              done,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_data,
  output logic              c_out,
  output logic              v_out,
  output logic              z_out,
  output logic              n_out
);

  localparam int UPPER_W   = DATA_W - LOGIC_W;
  localparam int PAD_FULL  = DATA_W - IMM_W;
  localparam int PAD_LOGIC = LOGIC_W - IMM_W;

  // internal reset: asserted asynchronously, released on a clock edge
  logic rst_n_i;

  ccu_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_i)
  );

  // predicate evaluation
  logic exec;

  ccu_gate u_gate (
    .imm_form (in_imm),
    .pred     (in_sub[3:2]),
    .c_flag   (c_in),
    .exec     (exec)
  );

  // operand shaping
  logic [DATA_W-1:0]  imm_zx_full;
  logic [LOGIC_W-1:0] imm_sx_low;
  logic [LOGIC_W-1:0] src_low;
  logic [DATA_W-1:0]  src_full;

  assign imm_zx_full = {{PAD_FULL{1'b0}}, in_imm7};
  assign imm_sx_low  = {{PAD_LOGIC{in_imm7[IMM_W-1]}}, in_imm7};
  assign src_low     = in_imm ? imm_sx_low  : in_rs[LOGIC_W-1:0];
  assign src_full    = in_imm ? imm_zx_full : in_rs;

  // bitwise logic datapath
  logic [LOGIC_W-1:0] lg_res;
  logic               lg_zero;
  logic               lg_neg;

  ccu_logic #(.W(LOGIC_W)) u_logic (
    .fn   (in_sub[1:0]),
    .a    (in_rd[LOGIC_W-1:0]),
    .b    (src_low),
    .res  (lg_res),
    .zero (lg_zero),
    .neg  (lg_neg)
  );

  // full-width plain compare
  logic fc_brw, fc_ovf, fc_zero, fc_neg;

  ccu_sub #(.W(DATA_W)) u_cmp_full (
    .a      (in_rd),
    .b      (src_full),
    .bin    (1'b0),
    .borrow (fc_brw),
    .ovf    (fc_ovf),
    .zero   (fc_zero),
    .neg    (fc_neg)
  );

  // low-width compare with carry-in as borrow
  logic bc_brw, bc_ovf, bc_zero, bc_neg;

  ccu_sub #(.W(LOGIC_W)) u_cmp_borrow (
    .a      (in_rd[LOGIC_W-1:0]),
    .b      (src_low),
    .bin    (c_in),
    .borrow (bc_brw),
    .ovf    (bc_ovf),
    .zero   (bc_zero),
    .neg    (bc_neg)
  );

  // next-state selection
  logic              wb_en_d;
  logic [DATA_W-1:0] wb_data_d;
  flags_t            flags_d;

  always_comb begin
    wb_en_d   = 1'b0;
    wb_data_d = '0;
    flags_d   = '{c: c_in, v: v_in, z: z_in, n: n_in};
    if (in_valid && exec) begin
      if (!in_grp) begin
        wb_en_d   = 1'b1;
        wb_data_d = {{UPPER_W{1'b0}}, lg_res};
        flags_d.v = 1'b0;
        flags_d.z = lg_zero;
        flags_d.n = lg_neg;
      end else begin
        case (cmp_fn_e'(in_sub[1:0]))
          CF_FULL:   flags_d = '{c: fc_brw, v: fc_ovf, z: fc_zero, n: fc_neg};
          CF_BORROW: flags_d = '{c: bc_brw, v: bc_ovf, z: bc_zero, n: bc_neg};
          default:   flags_d = '{c: c_in, v: v_in, z: z_in, n: n_in};
        endcase
      end
    end
  end

  // result registers
  logic              done_q;
  logic              wb_en_q;
  logic [DATA_W-1:0] wb_data_q;
  flags_t            flags_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      done_q    <= 1'b0;
      wb_en_q   <= 1'b0;
      wb_data_q <= '0;
      flags_q   <= '0;
    end else begin
      done_q    <= in_valid;
      wb_en_q   <= wb_en_d;
      wb_data_q <= wb_data_d;
      flags_q   <= flags_d;
    end
  end

  assign done    = done_q;
  assign wb_en   = wb_en_q;
  assign wb_data = wb_data_q;
  assign c_out   = flags_q.c;
  assign v_out   = flags_q.v;
  assign z_out   = flags_q.z;
  assign n_out   = flags_q.n;

endmodule

// File: rtl/ccu_chk.sv
module ccu_chk #(
  parameter int DATA_W  = 24,
  parameter int LOGIC_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_grp,
  input logic              in_imm,
  input logic [3:0]        in_sub,
  input logic              c_in,
  input logic              v_in,
  input logic              z_in,
  input logic              n_in,
  input logic              done,
  input logic              wb_en,
  input logic [DATA_W-1:0] wb_data,
  input logic              c_out,
  input logic              v_out,
  input logic              z_out,
  input logic              n_out
);

  // armed once the synchronised reset has let the result registers load
  logic [1:0] arm_cnt;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt <= 2'd0;
    end else if (arm_cnt != 2'd3) begin
      arm_cnt <= arm_cnt + 2'd1;
    end
  end

  assign armed = (arm_cnt == 2'd3);

  // R1
  done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (done == $past(in_valid)));

  // R4
  upper_byte_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data[DATA_W-1:LOGIC_W] == '0));

  // R6
  logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !v_out);

  // R6
  logic_c_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wb_en) |-> (c_out == $past(c_in)));

  // R9
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && in_grp)) |-> (!wb_en && wb_data == '0));

  // R3
  pred_fail_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && !in_imm && in_sub[3:2] == 2'b00 && !c_in))
      |-> (!wb_en && {c_out, v_out, z_out, n_out} == $past({c_in, v_in, z_in, n_in})));

  // R11
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_valid))
      |-> (!done && !wb_en && {c_out, v_out, z_out, n_out} == $past({c_in, v_in, z_in, n_in})));

endmodule

bind cond_cmp_logic_unit ccu_chk #(.DATA_W(DATA_W), .LOGIC_W(LOGIC_W)) u_chk (.*);

// File: tb/sim_cond_cmp_logic_unit.sv
module sim_cond_cmp_logic_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_grp;
  logic        in_imm;
  logic [3:0]  in_sub;
  logic [23:0] in_rd;
  logic [23:0] in_rs;
  logic [6:0]  in_imm7;
  logic        c_in, v_in, z_in, n_in;
  logic        done, wb_en;
  logic [23:0] wb_data;
  logic        c_out, v_out, z_out, n_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 0;

  cond_cmp_logic_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_grp(in_grp),
    .in_imm(in_imm), .in_sub(in_sub), .in_rd(in_rd), .in_rs(in_rs),
    .in_imm7(in_imm7), .c_in(c_in), .v_in(v_in), .z_in(z_in), .n_in(n_in),
    .done(done), .wb_en(wb_en), .wb_data(wb_data),
    .c_out(c_out), .v_out(v_out), .z_out(z_out), .n_out(n_out)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        grp;
    logic        imm;
    logic [3:0]  sub;
    logic [23:0] rd;
    logic [23:0] rs;
    logic [6:0]  im;
    logic [3:0]  fl;   // {C,V,Z,N}
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 4'b1000, 24'hFF1234, 24'h00FF0F, 7'h00, 4'b0000},
    '{1'b0, 1'b0, 4'b1001, 24'h001200, 24'h000034, 7'h00, 4'b1111},
    '{1'b0, 1'b0, 4'b1010, 24'hAA5555, 24'h00FFFF, 7'h00, 4'b0100},
    '{1'b0, 1'b0, 4'b1011, 24'h123456, 24'h000000, 7'h00, 4'b1000},
    '{1'b0, 1'b0, 4'b0001, 24'h000100, 24'h000001, 7'h00, 4'b1000},
    '{1'b0, 1'b0, 4'b0110, 24'h00F0F0, 24'h000F0F, 7'h00, 4'b0010},
    '{1'b0, 1'b1, 4'b0000, 24'h00ABCD, 24'h000000, 7'h3F, 4'b0000},
    '{1'b0, 1'b1, 4'b0001, 24'h001000, 24'h000000, 7'h41, 4'b0101},
    '{1'b0, 1'b1, 4'b1110, 24'h00FFFF, 24'h000000, 7'h7F, 4'b1000},
    '{1'b1, 1'b0, 4'b1000, 24'h123456, 24'h123456, 7'h00, 4'b0000},
    '{1'b1, 1'b0, 4'b1000, 24'h7FFFFF, 24'hFFFFFF, 7'h00, 4'b0000},
    '{1'b1, 1'b0, 4'b0000, 24'h000010, 24'h000020, 7'h00, 4'b1000},
    '{1'b1, 1'b1, 4'b0100, 24'h000100, 24'h000000, 7'h40, 4'b0001},
    '{1'b1, 1'b0, 4'b1001, 24'h008000, 24'h000000, 7'h00, 4'b1000},
    '{1'b1, 1'b0, 4'b0101, 24'h007FFF, 24'h00FFFF, 7'h00, 4'b0000},
    '{1'b1, 1'b1, 4'b1001, 24'h000005, 24'h000000, 7'h7E, 4'b1000}
  };

  // expected {wb_en, wb_data, C, V, Z, N} from the requirements
  function automatic logic [28:0] ref_model(input vec_t v);
    logic        ex;
    logic [15:0] s16, r16, d16;
    logic [23:0] s24, d24;
    logic        b;
    logic        vv;
    ref_model = {1'b0, 24'h0, v.fl};
    if (v.imm) ex = 1'b1;
    else if (v.sub[3:2] == 2'b10) ex = 1'b1;
    else if (v.sub[3:2] == 2'b00) ex = v.fl[3];
    else if (v.sub[3:2] == 2'b01) ex = !v.fl[3];
    else ex = 1'b0;
    if (!ex) return ref_model;
    s16 = v.imm ? {{9{v.im[6]}}, v.im} : v.rs[15:0];
    if (!v.grp) begin
      case (v.sub[1:0])
        2'b00: r16 = v.rd[15:0] & s16;
        2'b01: r16 = v.rd[15:0] | s16;
        2'b10: r16 = v.rd[15:0] ^ s16;
        default: r16 = ~s16;
      endcase
      ref_model = {1'b1, 8'h00, r16, v.fl[3], 1'b0, (r16 == 16'h0), r16[15]};
    end else if (v.sub[1:0] == 2'b00) begin
      s24 = v.imm ? {17'h0, v.im} : v.rs;
      {b, d24} = {1'b0, v.rd} - {1'b0, s24};
      vv = (v.rd[23] != s24[23]) && (d24[23] != v.rd[23]);
      ref_model = {1'b0, 24'h0, b, vv, (d24 == 24'h0), d24[23]};
    end else if (v.sub[1:0] == 2'b01) begin
      {b, d16} = {1'b0, v.rd[15:0]} - {1'b0, s16} - {16'h0, v.fl[3]};
      vv = (v.rd[15] != s16[15]) && (d16[15] != v.rd[15]);
      ref_model = {1'b0, 24'h0, b, vv, (d16 == 16'h0), d16[15]};
    end
  endfunction

  function automatic string tag_of(input vec_t v);
    if (!v.imm && v.sub[3:2] != 2'b10) return "R3";
    if (!v.grp) return v.imm ? "R5" : "R2";
    if (v.sub[1:0] == 2'b00) return "R7";
    if (v.sub[1:0] == 2'b01) return "R8";
    return "R10";
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [28:0] exp);
    logic [28:0] got;
    got = {wb_en, wb_data, c_out, v_out, z_out, n_out};
    n_checks++;
    if (got !== exp || done !== 1'b1) begin
      n_fails++;
      $display("FAIL %s: got done=%b {wb_en,wb_data,CVZN}=%h expected done=1 %h",
               tag, done, got, exp);
    end
  endtask

  // drive at the falling edge, outputs register at the next rising edge,
  // sample at the following falling edge
  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1;
    in_grp   = v.grp;
    in_imm   = v.imm;
    in_sub   = v.sub;
    in_rd    = v.rd;
    in_rs    = v.rs;
    in_imm7  = v.im;
    {c_in, v_in, z_in, n_in} = v.fl;
    @(negedge clk);
  endtask

  task automatic run_hand(input vec_t v, input logic [28:0] exp, input string tag);
    apply(v);
    check(tag, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_up();
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_grp   = 1'b0;
    in_imm   = 1'b0;
    in_sub   = 4'h0;
    in_rd    = '0;
    in_rs    = '0;
    in_imm7  = '0;
    {c_in, v_in, z_in, n_in} = 4'b1111;

    // R12: reset state, flag inputs held high to show they are not passed
    repeat (3) @(negedge clk);
    n_checks++;
    if ({done, wb_en, wb_data, c_out, v_out, z_out, n_out} !== 30'h0) begin
      n_fails++;
      $display("FAIL R12: got %h expected 0",
               {done, wb_en, wb_data, c_out, v_out, z_out, n_out});
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // vector table walk
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      check(tag_of(VECS[i]), ref_model(VECS[i]));
    end

    // R7: 0 - 1 borrows, negative
    run_hand('{1'b1, 1'b0, 4'b1000, 24'h000000, 24'h000001, 7'h00, 4'b0000},
             {1'b0, 24'h0, 4'b1001}, "R7");
    // R7: signed overflow at the 24-bit boundary
    run_hand('{1'b1, 1'b0, 4'b1000, 24'h800000, 24'h000001, 7'h00, 4'b0000},
             {1'b0, 24'h0, 4'b0100}, "R7");
    // R7: immediate is zero-extended (0x7F vs rd 0x7F gives zero)
    run_hand('{1'b1, 1'b1, 4'b0000, 24'h00007F, 24'h000000, 7'h7F, 4'b0000},
             {1'b0, 24'h0, 4'b0010}, "R7");
    // R8: upper byte ignored, carry subtracted: 5-4-1 = 0
    run_hand('{1'b1, 1'b0, 4'b1001, 24'hAB0005, 24'hFF0004, 7'h00, 4'b1000},
             {1'b0, 24'h0, 4'b0010}, "R8");
    // R8: immediate sign-extended: 0 - 0xFFFF borrows, result 1
    run_hand('{1'b1, 1'b1, 4'b0001, 24'h000000, 24'h000000, 7'h7F, 4'b0000},
             {1'b0, 24'h0, 4'b1000}, "R8");
    // R5: NOT of sign-extended 0x40 (0xFFC0) is 0x003F
    run_hand('{1'b0, 1'b1, 4'b0011, 24'hFFFFFF, 24'h000000, 7'h40, 4'b1000},
             {1'b1, 24'h00003F, 4'b1000}, "R5");
    // R4 / R6: AND clears upper byte, V cleared, N from bit 15
    run_hand('{1'b0, 1'b0, 4'b1000, 24'hFFFFFF, 24'hFF8000, 7'h00, 4'b0100},
             {1'b1, 24'h008000, 4'b0001}, "R4");
    // R6: XOR of equal low halves gives Z, C kept
    run_hand('{1'b0, 1'b0, 4'b1010, 24'h123456, 24'h003456, 7'h00, 4'b1001},
             {1'b1, 24'h000000, 4'b1010}, "R6");
    // R3: if-C with C=0 is a no-op
    run_hand('{1'b0, 1'b0, 4'b0000, 24'hFFFFFF, 24'hFFFFFF, 7'h00, 4'b0111},
             {1'b0, 24'h0, 4'b0111}, "R3");
    // R3: if-no-C with C=1 is a no-op
    run_hand('{1'b0, 1'b0, 4'b0101, 24'h00FFFF, 24'h000001, 7'h00, 4'b1001},
             {1'b0, 24'h0, 4'b1001}, "R3");
    // R3: predicate 11 never executes
    run_hand('{1'b0, 1'b0, 4'b1110, 24'h001234, 24'h001234, 7'h00, 4'b0110},
             {1'b0, 24'h0, 4'b0110}, "R3");
    // R10: reserved compare function
    run_hand('{1'b1, 1'b0, 4'b1010, 24'h000000, 24'h000001, 7'h00, 4'b0011},
             {1'b0, 24'h0, 4'b0011}, "R10");
    // R9: compare with a would-be nonzero difference still writes nothing
    run_hand('{1'b1, 1'b0, 4'b1000, 24'h00FFFF, 24'h000001, 7'h00, 4'b0000},
             {1'b0, 24'h0, 4'b0000}, "R9");

    // R11 / R1: idle cycle passes flags through, done low
    @(negedge clk);
    in_valid = 1'b0;
    in_grp   = 1'b0;
    in_sub   = 4'b1011;
    {c_in, v_in, z_in, n_in} = 4'b1010;
    @(negedge clk);
    n_checks++;
    if ({done, wb_en, c_out, v_out, z_out, n_out} !== 6'b00_1010) begin
      n_fails++;
      $display("FAIL R11: got %b expected 001010",
               {done, wb_en, c_out, v_out, z_out, n_out});
    end

    // R1: result appears one edge after presentation, not before
    @(negedge clk);
    in_valid = 1'b1;
    in_grp   = 1'b0;
    in_imm   = 1'b0;
    in_sub   = 4'b1001;
    in_rd    = 24'h000F00;
    in_rs    = 24'h0000F0;
    {c_in, v_in, z_in, n_in} = 4'b0000;
    #1;
    n_checks++;
    if (done !== 1'b0 || wb_en !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: got done=%b wb_en=%b expected 0 0 before the edge", done, wb_en);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {1'b1, 24'h000FF0, 4'b0000});

    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule